// File: doc/BRIEF.md
# Doorbell Interrupt Register Pair

This block lets software running on one processor raise an interrupt toward a host and leave a record of which source asked for it. It presents two 32-bit registers on a simple register bus. Both registers are views of one shared set of 28 source flags. A write to the raise register sets flags wherever the written data holds a one. A write to the retire register clears flags wherever the written data holds a one.

Bit 0 of the raise register is a self-clearing trigger. Writing a one to it produces a single-cycle pulse on the host interrupt output. The host reads either register to see which sources are pending, then retires them. Writes are accepted on the clock edge. Reads return, without a register stage, the state held in the flops.

Top module: `dbell_regs`

## Requirements
- R1: After reset all 28 flags are 0, `host_irq_pulse` is 0 and both registers read 0x00000000.
- R2: A write to offset 0x0 (raise) sets flag x wherever data bit x+4 is 1. Flags whose data bit is 0 keep their value.
- R3: A write to offset 0x4 (retire) clears flag x wherever data bit x+4 is 1. Flags whose data bit is 0 keep their value.
- R4: Reads of offset 0x0 and offset 0x4 both return the current flags in bits 31:4.
- R5: A raise write with data bit 0 equal to 1 drives `host_irq_pulse` high for exactly the one cycle after the write edge. A write with bit 0 equal to 0 produces no pulse. Triggers on consecutive cycles give pulses on consecutive cycles.
- R6: Bits 3:0 of both registers, including the trigger bit, always read 0. Data in bits 3:0 never changes a flag.
- R7: When one raise write both sets flags and triggers, the new flags are readable in the same cycle that the pulse is high.
- R8: Writes to any offset other than 0x0 and 0x4 change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, from registered state |
| host_irq_pulse | output | 1 | One-cycle interrupt pulse toward the host |

## Verification
A flag that is wrongly set or cleared shows up on the very next read of either offset, because reads come straight from the flop state. The bench therefore reads both offsets after every operation, and a fault in the store is visible one cycle after the write that caused it. A trigger fault shows on `host_irq_pulse` in the cycle right after the write edge, as a missing, stretched or spurious pulse. The bench samples every cycle around each trigger to catch it.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned FLAG_LSB    = 4;
  localparam int unsigned FLAG_COUNT  = REG_W - FLAG_LSB;
  localparam int unsigned TRIG_BIT    = 0;
  localparam int unsigned OFS_RAISE   = 0;
  localparam int unsigned OFS_RETIRE  = 4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_RAISE  = 2'd1,
    SEL_RETIRE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NFLAGS  = FLAG_COUNT,
  parameter int unsigned LSB     = FLAG_LSB
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic [REG_W-1:0]       wdata,
  output reg_sel_e               sel,
  output logic [NFLAGS-1:0]      set_mask,
  output logic [NFLAGS-1:0]      clr_mask,
  output logic                   trig
);
  localparam logic [ADDR_W-1:0] A_RAISE  = ADDR_W'(OFS_RAISE);
  localparam logic [ADDR_W-1:0] A_RETIRE = ADDR_W'(OFS_RETIRE);

  always_comb begin
    if (addr == A_RAISE)       sel = SEL_RAISE;
    else if (addr == A_RETIRE) sel = SEL_RETIRE;
    else                       sel = SEL_NONE;
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    trig     = 1'b0;
    if (wr_en) begin
      if (sel == SEL_RAISE) begin
        set_mask = wdata[LSB +: NFLAGS];
        trig     = wdata[TRIG_BIT];
      end else if (sel == SEL_RETIRE) begin
        clr_mask = wdata[LSB +: NFLAGS];
      end
    end
  end
endmodule

// File: rtl/dbell_flag_store.sv
module dbell_flag_store #(
  parameter int unsigned NFLAGS = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAGS-1:0] set_mask,
  input  logic [NFLAGS-1:0] clr_mask,
  output logic [NFLAGS-1:0] flags
);
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flags[i] <= 1'b0;
      else if (set_mask[i]) flags[i] <= 1'b1;
      else if (clr_mask[i]) flags[i] <= 1'b0;
    end
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    ((flags & $past(set_mask)) == $past(set_mask))); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    ((flags & $past(clr_mask & ~set_mask)) == '0)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(set_mask) == '0 && $past(clr_mask) == '0) |-> $stable(flags)); // R8
endmodule

// File: rtl/dbell_pulse.sv
module dbell_pulse (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= trig;
  end
endmodule

// File: rtl/dbell_readmux.sv
module dbell_readmux
  import dbell_pkg::*;
#(
  parameter int unsigned NFLAGS = FLAG_COUNT,
  parameter int unsigned LSB    = FLAG_LSB
) (
  input  reg_sel_e          sel,
  input  logic [NFLAGS-1:0] flags,
  output logic [REG_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (sel != SEL_NONE) rdata[LSB +: NFLAGS] = flags;
  end
endmodule

// File: rtl/dbell_regs.sv
module dbell_regs
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              host_irq_pulse
);
  localparam int unsigned NFLAGS = FLAG_COUNT;

  reg_sel_e          sel;
  logic [NFLAGS-1:0] set_mask;
  logic [NFLAGS-1:0] clr_mask;
  logic [NFLAGS-1:0] flags;
  logic              trig;

  dbell_decode #(.ADDR_W(ADDR_W), .NFLAGS(NFLAGS), .LSB(FLAG_LSB)) i_decode (
    .addr(bus_addr), .wr_en(bus_wr_en), .wdata(bus_wdata),
    .sel(sel), .set_mask(set_mask), .clr_mask(clr_mask), .trig(trig)
  );

  dbell_flag_store #(.NFLAGS(NFLAGS)) i_store (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .flags(flags)
  );

  dbell_pulse i_pulse (
    .clk(clk), .rst(rst), .trig(trig), .pulse(host_irq_pulse)
  );

  dbell_readmux #(.NFLAGS(NFLAGS), .LSB(FLAG_LSB)) i_rmux (
    .sel(sel), .flags(flags), .rdata(bus_rdata)
  );

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    host_irq_pulse |-> $past(bus_wr_en && bus_addr == ADDR_W'(OFS_RAISE) && bus_wdata[0])); // R5
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == ADDR_W'(OFS_RAISE) && bus_wdata[0]) |=> host_irq_pulse); // R5
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[FLAG_LSB-1:0] == '0); // R6
endmodule

// File: tb/test_dbell_regs.sv
module test_dbell_regs;
  localparam int unsigned ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr_en = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              host_irq_pulse;

  int unsigned errors = 0;
  int unsigned checks = 0;
  logic [27:0] model = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbell_regs #(.ADDR_W(ADDR_W)) i_dbell_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq_pulse(host_irq_pulse)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [27:0] f);
    if (a == 8'h00 || a == 8'h04) return {f, 4'b0000};
    return 32'h0;
  endfunction

  function automatic logic [27:0] next_flags(input logic [7:0] a, input logic [31:0] d,
                                             input logic [27:0] f);
    if (a == 8'h00) return f | d[31:4];
    if (a == 8'h04) return f & ~d[31:4];
    return f;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] a);
    bus_wr_en = 1'b0;
    bus_addr  = a;
    #1;
    check(req, bus_rdata, exp_read(a, model));
  endtask

  // Drive at the falling edge, let the rising edge take it, check at the next falling edge.
  task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
    logic exp_p;
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    exp_p = (a == 8'h00) && d[0];
    @(posedge clk);
    @(negedge clk);
    model = next_flags(a, d, model);
    check({req, " pulse R5"}, {31'b0, host_irq_pulse}, {31'b0, exp_p});
  endtask

  task automatic idle_chk(input string req);
    bus_wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req, {31'b0, host_irq_pulse}, 32'h0);
  endtask

  task automatic read_both(input string req);
    read_chk({req, " raise view"}, 8'h00);
    read_chk({req, " retire view"}, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pulse", {31'b0, host_irq_pulse}, 32'h0);
    read_both("R1");

    // R2 R7: set all and trigger together, flags visible while pulse high
    wr("R2", 8'h00, 32'hFFFF_FFF1);
    read_both("R7 flags with pulse");
    idle_chk("R5 pulse single cycle");

    // R6: low bits on retire have no effect
    wr("R6", 8'h04, 32'h0000_000F);
    read_both("R6 low bits ignored");

    // R3: clear a pattern, zeros keep
    wr("R3", 8'h04, 32'hA5A5_5A50);
    read_both("R3 clear pattern");

    // R2 zeros keep, no trigger
    wr("R2", 8'h00, 32'h0000_0000);
    read_both("R2 zero write");

    // R8 unmapped write and read
    wr("R8", 8'h08, 32'hFFFF_FFFF);
    read_both("R8 unmapped write ignored");
    read_chk("R8 unmapped read", 8'h08);
    read_chk("R8 unmapped read", 8'hFC);

    // R5 back-to-back triggers, then trigger with no flag data
    wr("R5 first", 8'h00, 32'h0000_0001);
    wr("R5 second", 8'h00, 32'h0000_0001);
    idle_chk("R5 pulse ends");
    read_both("R6 trigger reads 0");

    // R3 clear all
    wr("R3", 8'h04, 32'hFFFF_FFF0);
    read_both("R3 clear all");

    // Random mix against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int unsigned k;
      k = $urandom_range(0, 9);
      if (k < 4)      a = 8'h00;
      else if (k < 8) a = 8'h04;
      else            a = 8'($urandom_range(0, 255));
      d = $urandom;
      wr("R2 R3 R5 random", a, d);
      if ($urandom_range(0, 3) == 0) idle_chk("R5 random idle");
      read_both("R4 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule